// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Burst Address Counters

This block is a word-organised synchronous static RAM with two ports that share one clock and one storage array. Each port keeps its own burst pointer. On every rising edge the pointer of a port is cleared to zero, loaded from the port's address input, stepped by one, or left unchanged. The resulting pointer value is the address of that cycle's access. A port can therefore run random accesses, walk through memory in bursts, or stay on one word, with no idle cycles between these modes.

A port takes part in a cycle only when both of its selects agree. Writes are gated per byte lane. Reads report which byte lanes carry data through a per-lane valid flag, and any lane that is not valid is driven to zero. A parameter picks the read timing. In flow-through mode the word follows the access edge combinationally. In pipelined mode the word comes from an output register one clock later. The full-size configuration is `ADDR_W = 14`, which gives 16384 words of 16 bits. The default is smaller so that the block elaborates quickly.

Top module: `burst_dpram`

## Requirements
- R1: When a port's load strobe (`*_load_n`) is 0 and its clear (`*_zero_n`) is 1 at a rising edge, the access address of that cycle is `*_addr`, and the pointer keeps that value.
- R2: When clear and load are both 1 and the step input (`*_step_n`) is 0, the pointer becomes its old value plus one, and the access goes to the new value.
- R3: When clear, load and step are all 1, the pointer is unchanged, so repeated cycles read or write the same word.
- R4: When `*_zero_n` is 0, the pointer becomes 0 whatever load and step do, and the access of that same cycle goes to address 0.
- R5: Stepping from the last address (2^ADDR_W−1) wraps the pointer to 0.
- R6: A port is selected only when `*_sel_n` is 0 and `*_sel` is 1. An unselected cycle writes nothing and gives all-zero read valid flags. The pointer still follows R1–R4 in that cycle.
- R7: `*_rd` = 0 means write. Byte lane i (bits 8i+7..8i, lane 1 is the upper byte) is written only when `*_lane_n[i]` is 0.
- R8: A selected read with `*_rd` = 1 sets `*_rvalid[i]` = ~`*_lane_n[i]`. A write or deselect cycle sets every flag to 0. Each byte of `*_rdata` whose flag is 0 reads as zero.
- R9: With `PIPELINED` = 0, data and flags of an access at edge k are present after edge k. With `PIPELINED` = 1, they appear after edge k+1.
- R10: Both ports reach the same storage: a word written through one port is read back through the other.
- R11: Reset clears both pointers to 0 and all read valid flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_sel_n | input | 1 | Port A select, active low |
| a_sel | input | 1 | Port A select, active high |
| a_rd | input | 1 | Port A direction, 1 read, 0 write |
| a_load_n | input | 1 | Port A pointer load from a_addr, active low |
| a_step_n | input | 1 | Port A pointer increment, active low |
| a_zero_n | input | 1 | Port A pointer clear, active low |
| a_lane_n | input | LANES | Port A byte lane enables, active low |
| a_addr | input | ADDR_W | Port A external address |
| a_wdata | input | LANES*BYTE_W | Port A write word |
| a_rdata | output | LANES*BYTE_W | Port A read word, lanes masked by a_rvalid |
| a_rvalid | output | LANES | Port A per-lane read valid |
| b_sel_n | input | 1 | Port B select, active low |
| b_sel | input | 1 | Port B select, active high |
| b_rd | input | 1 | Port B direction, 1 read, 0 write |
| b_load_n | input | 1 | Port B pointer load from b_addr, active low |
| b_step_n | input | 1 | Port B pointer increment, active low |
| b_zero_n | input | 1 | Port B pointer clear, active low |
| b_lane_n | input | LANES | Port B byte lane enables, active low |
| b_addr | input | ADDR_W | Port B external address |
| b_wdata | input | LANES*BYTE_W | Port B write word |
| b_rdata | output | LANES*BYTE_W | Port B read word, lanes masked by b_rvalid |
| b_rvalid | output | LANES | Port B per-lane read valid |

## Verification
The pointer properties assume that the control inputs are known and steady around each rising edge, and that while reset is held the controls request a hold. The stimulus changes inputs only on falling edges and parks both ports deselected in hold during reset. Collisions between the two ports are outside the block's behaviour. The sequences therefore never let one port write a word in the same cycle that the other port touches it, so the bench's arithmetic memory model stays exact.

// File: rtl/burst_dpram.sv
module burst_dpram #(
  parameter int ADDR_W    = 10,
  parameter int BYTE_W    = 8,
  parameter int LANES     = 2,
  parameter bit PIPELINED = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      a_sel_n,
  input  logic                      a_sel,
  input  logic                      a_rd,
  input  logic                      a_load_n,
  input  logic                      a_step_n,
  input  logic                      a_zero_n,
  input  logic [LANES-1:0]          a_lane_n,
  input  logic [ADDR_W-1:0]         a_addr,
  input  logic [LANES*BYTE_W-1:0]   a_wdata,
  output logic [LANES*BYTE_W-1:0]   a_rdata,
  output logic [LANES-1:0]          a_rvalid,
  input  logic                      b_sel_n,
  input  logic                      b_sel,
  input  logic                      b_rd,
  input  logic                      b_load_n,
  input  logic                      b_step_n,
  input  logic                      b_zero_n,
  input  logic [LANES-1:0]          b_lane_n,
  input  logic [ADDR_W-1:0]         b_addr,
  input  logic [LANES*BYTE_W-1:0]   b_wdata,
  output logic [LANES*BYTE_W-1:0]   b_rdata,
  output logic [LANES-1:0]          b_rvalid
);
  localparam int DATA_W = LANES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NP     = 2;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              sel    [NP];
  logic              rd     [NP];
  logic              load_n [NP];
  logic              step_n [NP];
  logic              zero_n [NP];
  logic [LANES-1:0]  lane_n [NP];
  logic [ADDR_W-1:0] addr   [NP];
  logic [DATA_W-1:0] wdata  [NP];

  logic [ADDR_W-1:0] ptr      [NP];
  logic [ADDR_W-1:0] nxt      [NP];
  logic [LANES-1:0]  rlane_q  [NP];
  logic [DATA_W-1:0] ft_data  [NP];
  logic [DATA_W-1:0] out_data [NP];
  logic [LANES-1:0]  out_lane [NP];
  logic [DATA_W-1:0] out_mask [NP];

  assign sel[0]    = !a_sel_n && a_sel;
  assign sel[1]    = !b_sel_n && b_sel;
  assign rd[0]     = a_rd;
  assign rd[1]     = b_rd;
  assign load_n[0] = a_load_n;
  assign load_n[1] = b_load_n;
  assign step_n[0] = a_step_n;
  assign step_n[1] = b_step_n;
  assign zero_n[0] = a_zero_n;
  assign zero_n[1] = b_zero_n;
  assign lane_n[0] = a_lane_n;
  assign lane_n[1] = b_lane_n;
  assign addr[0]   = a_addr;
  assign addr[1]   = b_addr;
  assign wdata[0]  = a_wdata;
  assign wdata[1]  = b_wdata;

  for (genvar p = 0; p < NP; p++) begin : g_port
    always_comb begin
      if (!zero_n[p])      nxt[p] = '0;
      else if (!load_n[p]) nxt[p] = addr[p];
      else if (!step_n[p]) nxt[p] = ptr[p] + 1'b1;
      else                 nxt[p] = ptr[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr[p]     <= '0;
        rlane_q[p] <= '0;
      end else begin
        ptr[p]     <= nxt[p];
        rlane_q[p] <= (sel[p] && rd[p]) ? ~lane_n[p] : '0;
      end
    end

    assign ft_data[p] = mem[ptr[p]];

    if (PIPELINED) begin : g_pipe
      logic [DATA_W-1:0] dout_q;
      logic [LANES-1:0]  lane_qq;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dout_q  <= '0;
          lane_qq <= '0;
        end else begin
          dout_q  <= ft_data[p];
          lane_qq <= rlane_q[p];
        end
      end
      assign out_data[p] = dout_q;
      assign out_lane[p] = lane_qq;
    end else begin : g_flow
      assign out_data[p] = ft_data[p];
      assign out_lane[p] = rlane_q[p];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_mask
      assign out_mask[p][l*BYTE_W +: BYTE_W] = {BYTE_W{out_lane[p][l]}};
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      for (int l = 0; l < LANES; l++) begin
        if (sel[p] && !rd[p] && !lane_n[p][l])
          mem[nxt[p]][l*BYTE_W +: BYTE_W] <= wdata[p][l*BYTE_W +: BYTE_W];
      end
    end
  end

  assign a_rdata  = out_data[0] & out_mask[0];
  assign a_rvalid = out_lane[0];
  assign b_rdata  = out_data[1] & out_mask[1];
  assign b_rvalid = out_lane[1];
endmodule

// File: rtl/burst_dpram_chk.sv
module burst_dpram_chk #(
  parameter int ADDR_W    = 10,
  parameter int LANES     = 2,
  parameter bit PIPELINED = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              rd,
  input logic              load_n,
  input logic              step_n,
  input logic              zero_n,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] ptr,
  input logic [LANES-1:0]  lane_q,
  input logic [LANES-1:0]  rvalid
);
  // R4
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_n |=> ptr == '0);

  // R1
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && !load_n) |=> ptr == $past(addr));

  // R2
  step_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && load_n && !step_n) |=> ptr == ADDR_W'($past(ptr) + 1'b1));

  // R3
  hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && load_n && step_n) |=> $stable(ptr));

  // R6
  deselect_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> lane_q == '0);

  // R8
  write_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !rd) |=> lane_q == '0);

  if (PIPELINED) begin : g_pipe_chk
    // R9
    pipe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> rvalid == $past(lane_q));
  end
endmodule

bind burst_dpram burst_dpram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .PIPELINED(PIPELINED)) u_chk_a (
  .clk(clk), .rst_n(rst_n), .sel(!a_sel_n && a_sel), .rd(a_rd),
  .load_n(a_load_n), .step_n(a_step_n), .zero_n(a_zero_n), .addr(a_addr),
  .ptr(ptr[0]), .lane_q(rlane_q[0]), .rvalid(a_rvalid));

bind burst_dpram burst_dpram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .PIPELINED(PIPELINED)) u_chk_b (
  .clk(clk), .rst_n(rst_n), .sel(!b_sel_n && b_sel), .rd(b_rd),
  .load_n(b_load_n), .step_n(b_step_n), .zero_n(b_zero_n), .addr(b_addr),
  .ptr(ptr[1]), .lane_q(rlane_q[1]), .rvalid(b_rvalid));

// File: tb/burst_dpram_bench.sv
`timescale 1ns/1ps
module burst_dpram_bench;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic a_sel_n, a_sel, a_rd, a_load_n, a_step_n, a_zero_n;
  logic b_sel_n, b_sel, b_rd, b_load_n, b_step_n, b_zero_n;
  logic [1:0] a_lane_n, b_lane_n;
  logic [AW-1:0] a_addr, b_addr;
  logic [15:0] a_wdata, b_wdata;
  logic [15:0] pa_rdata, pb_rdata, fa_rdata, fb_rdata;
  logic [1:0]  pa_rvalid, pb_rvalid, fa_rvalid, fb_rvalid;

  burst_dpram #(.ADDR_W(AW), .PIPELINED(1'b1)) u_burst_dpram (
    .clk(clk), .rst_n(rst_n),
    .a_sel_n(a_sel_n), .a_sel(a_sel), .a_rd(a_rd), .a_load_n(a_load_n),
    .a_step_n(a_step_n), .a_zero_n(a_zero_n), .a_lane_n(a_lane_n),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(pa_rdata), .a_rvalid(pa_rvalid),
    .b_sel_n(b_sel_n), .b_sel(b_sel), .b_rd(b_rd), .b_load_n(b_load_n),
    .b_step_n(b_step_n), .b_zero_n(b_zero_n), .b_lane_n(b_lane_n),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(pb_rdata), .b_rvalid(pb_rvalid));

  burst_dpram #(.ADDR_W(AW), .PIPELINED(1'b0)) u_burst_dpram_ft (
    .clk(clk), .rst_n(rst_n),
    .a_sel_n(a_sel_n), .a_sel(a_sel), .a_rd(a_rd), .a_load_n(a_load_n),
    .a_step_n(a_step_n), .a_zero_n(a_zero_n), .a_lane_n(a_lane_n),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(fa_rdata), .a_rvalid(fa_rvalid),
    .b_sel_n(b_sel_n), .b_sel(b_sel), .b_rd(b_rd), .b_load_n(b_load_n),
    .b_step_n(b_step_n), .b_zero_n(b_zero_n), .b_lane_n(b_lane_n),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(fb_rdata), .b_rvalid(fb_rvalid));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0]   mdl [N];
  logic [AW-1:0] cnt [2];
  logic [17:0]   prev [2];

  function automatic logic [15:0] pat(input int i);
    return 16'((i * 16'h0F1D) ^ 16'h5A3C);
  endfunction

  task automatic chk(input string tag, input string who, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, who, act, exp);
    end
  endtask

  task automatic set_p(input int p, input logic sn, input logic s, input logic rd,
                       input logic ld, input logic st, input logic zr,
                       input logic [1:0] ln, input logic [AW-1:0] ad, input logic [15:0] wd);
    if (p == 0) begin
      a_sel_n = sn; a_sel = s; a_rd = rd; a_load_n = ld; a_step_n = st;
      a_zero_n = zr; a_lane_n = ln; a_addr = ad; a_wdata = wd;
    end else begin
      b_sel_n = sn; b_sel = s; b_rd = rd; b_load_n = ld; b_step_n = st;
      b_zero_n = zr; b_lane_n = ln; b_addr = ad; b_wdata = wd;
    end
  endtask

  task automatic idle(input int p);
    set_p(p, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, '0, '0);
  endtask

  // one clock: update the model, then compare flow-through now and pipelined one edge later
  task automatic step(input string tag);
    logic sl [2]; logic rdv [2]; logic ldv [2]; logic stv [2]; logic zrv [2];
    logic [1:0] lnv [2]; logic [AW-1:0] adv [2]; logic [15:0] wdv [2];
    logic [1:0] ev [2]; logic [17:0] ex [2];
    sl[0] = !a_sel_n && a_sel; sl[1] = !b_sel_n && b_sel;
    rdv[0] = a_rd; rdv[1] = b_rd; ldv[0] = a_load_n; ldv[1] = b_load_n;
    stv[0] = a_step_n; stv[1] = b_step_n; zrv[0] = a_zero_n; zrv[1] = b_zero_n;
    lnv[0] = a_lane_n; lnv[1] = b_lane_n; adv[0] = a_addr; adv[1] = b_addr;
    wdv[0] = a_wdata; wdv[1] = b_wdata;
    for (int p = 0; p < 2; p++) begin
      logic [AW-1:0] nx;
      if (!zrv[p]) nx = '0;
      else if (!ldv[p]) nx = adv[p];
      else if (!stv[p]) nx = cnt[p] + 1'b1;
      else nx = cnt[p];
      if (sl[p] && !rdv[p]) begin
        if (!lnv[p][0]) mdl[nx][7:0]  = wdv[p][7:0];
        if (!lnv[p][1]) mdl[nx][15:8] = wdv[p][15:8];
      end
      cnt[p] = nx;
      ev[p] = (sl[p] && rdv[p]) ? ~lnv[p] : 2'b00;
    end
    for (int p = 0; p < 2; p++)
      ex[p] = {ev[p], mdl[cnt[p]] & {{8{ev[p][1]}}, {8{ev[p][0]}}}};
    @(posedge clk);
    @(negedge clk);
    chk({tag, "/R9"}, "flow A", {fa_rvalid, fa_rdata}, ex[0]);
    chk({tag, "/R9"}, "flow B", {fb_rvalid, fb_rdata}, ex[1]);
    chk({tag, "/R9"}, "pipe A", {pa_rvalid, pa_rdata}, prev[0]);
    chk({tag, "/R9"}, "pipe B", {pb_rvalid, pb_rdata}, prev[1]);
    prev[0] = ex[0];
    prev[1] = ex[1];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(0); idle(1);
    cnt[0] = '0; cnt[1] = '0; prev[0] = '0; prev[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: valid flags clear after reset
    chk("R11", "pipe A", {pa_rvalid, pa_rdata}, '0);
    chk("R11", "pipe B", {pb_rvalid, pb_rdata}, '0);
    chk("R11", "flow A", {fa_rvalid, fa_rdata}, '0);
    chk("R11", "flow B", {fb_rvalid, fb_rdata}, '0);

    // R11: a hold write right after reset lands on address 0
    set_p(0, 0, 1, 0, 1, 1, 1, 2'b00, 4'd9, 16'hC3A5); step("R11");
    idle(0);
    set_p(1, 0, 1, 1, 0, 1, 1, 2'b00, 4'd0, '0); step("R11");
    idle(1); step("R11");

    // R1: random-order loads write every word
    for (int i = 0; i < N; i++) begin
      set_p(0, 0, 1, 0, 0, 1, 1, 2'b00, AW'((i * 5 + 2) % N), pat(i));
      step("R1");
    end
    idle(0);
    // R10: read every word back through the other port
    for (int i = 0; i < N; i++) begin
      set_p(1, 0, 1, 1, 0, 1, 1, 2'b00, AW'((i * 7 + 3) % N), '0);
      step("R10");
    end

    // R2 / R5: A loads 13 then steps across the wrap; B bursts writes from 8
    set_p(0, 0, 1, 1, 0, 1, 1, 2'b00, 4'd13, '0);
    set_p(1, 0, 1, 0, 0, 1, 1, 2'b00, 4'd8, 16'h1111);
    step("R2");
    for (int i = 0; i < 5; i++) begin
      set_p(0, 0, 1, 1, 1, 0, 1, 2'b00, '0, '0);
      set_p(1, 0, 1, 0, 1, 0, 1, 2'b00, 4'd15, 16'(16'h2222 * (i + 1)));
      step("R5");
    end
    idle(1);
    set_p(1, 0, 1, 1, 0, 1, 1, 2'b00, 4'd8, '0); step("R2");
    for (int i = 0; i < 5; i++) begin
      set_p(1, 0, 1, 1, 1, 0, 1, 2'b00, '0, '0);
      step("R2");
    end

    // R3: hold reads and hold writes
    idle(1);
    for (int i = 0; i < 3; i++) begin
      set_p(0, 0, 1, 1, 1, 1, 1, 2'b00, 4'd7, '0);
      step("R3");
    end
    for (int i = 0; i < 3; i++) begin
      set_p(0, 0, 1, 0, 1, 1, 1, 2'b00, 4'd7, 16'(16'h0F0F + i));
      step("R3");
    end
    set_p(0, 0, 1, 1, 1, 1, 1, 2'b00, '0, '0); step("R3");

    // R4: clear wins over load and step, same-cycle access at address 0
    set_p(0, 0, 1, 0, 0, 0, 0, 2'b00, 4'd9, 16'hBEEF); step("R4");
    set_p(0, 0, 1, 1, 1, 1, 1, 2'b00, 4'd9, '0); step("R4");
    set_p(0, 0, 1, 1, 1, 0, 0, 2'b00, 4'd9, '0); step("R4");
    set_p(1, 0, 1, 1, 0, 1, 0, 2'b00, 4'd3, '0); step("R4");
    idle(1);

    // R6: one select missing blocks a write
    set_p(0, 0, 1, 1, 0, 1, 1, 2'b00, 4'd5, '0); step("R6");
    set_p(0, 1, 1, 0, 0, 1, 1, 2'b00, 4'd5, 16'hFFFF); step("R6");
    set_p(0, 0, 0, 0, 0, 1, 1, 2'b00, 4'd5, 16'hFFFF); step("R6");
    set_p(0, 1, 0, 1, 0, 1, 1, 2'b00, 4'd5, 16'hFFFF); step("R6");
    set_p(0, 0, 1, 1, 0, 1, 1, 2'b00, 4'd5, '0); step("R6");

    // R7: every byte-lane write pattern, each read back whole
    for (int c = 0; c < 4; c++) begin
      set_p(0, 0, 1, 0, 0, 1, 1, 2'(c), 4'd6, 16'(~pat(c + 20))); step("R7");
      set_p(0, 0, 1, 1, 0, 1, 1, 2'b00, 4'd6, '0); step("R7");
    end

    // R8: every byte-lane read pattern
    for (int c = 0; c < 4; c++) begin
      set_p(1, 0, 1, 1, 0, 1, 1, 2'(c), 4'd6, '0); step("R8");
    end

    // R5: full burst from 0 through the wrap
    idle(0);
    set_p(1, 0, 1, 1, 0, 1, 1, 2'b00, 4'd0, '0); step("R5");
    for (int i = 0; i < N + 1; i++) begin
      set_p(1, 0, 1, 1, 1, 0, 1, 2'b00, '0, '0);
      step("R5");
    end
    idle(1);
    step("R9"); step("R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule